// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine with Ring Mode

This block is one DMA channel. Each accepted transfer request makes it read a byte or a 16-bit halfword from a source address and write that value to a destination address. It is configured through a simple register-write port. A registered readback port returns the channel's live state. The memory master side assumes an ideal memory: read data arrives on the cycle after the read strobe, and there are no wait states.

Each of the two addresses can be set to stay fixed or to advance by the transfer size. An 8-bit counter steps down once per transfer. In normal mode the channel finishes when that counter passes below zero. At that point it clears its own enable, sets a sticky status flag and, unless masked, drives the interrupt output. In ring mode the counter simply wraps and transfers go on until software turns the channel off. No completion status is ever raised in ring mode.

Register map (write address / readback select, 3 bits): 0 = control, 1 = source address, 2 = destination address, 3 = transfer count, 4 = interrupt mask (bit 0), 5 = status (reads bit 0; writing bit 0 as 1 clears it). Control bits are:
- bit 0 enable
- bit 1 ring mode
- bit 2 halfword size (0 = byte)
- bit 3 source increments
- bit 4 destination increments

Top module: `dmach_top`

## Requirements
- R1: After reset the control register reads 0, both addresses read 0, the count reads 0xFF, the mask and the status read 0, irq is low and mem_req is low.
- R2: A rising edge on xfer_req sampled at a clock edge while enabled starts a transfer. In the next cycle mem_req=1 and mem_we=0 with the source address. The cycle after that, mem_req=0. In the third cycle mem_req=1 and mem_we=1 with the destination address and the data read.
- R3: An address whose increment bit is 0 keeps its loaded value through any number of transfers.
- R4: An address whose increment bit is 1 advances by 1 after each byte transfer and by 2 after each halfword transfer.
- R5: In normal mode a loaded count N gives exactly N+1 transfers. After the last one the enable bit reads 0, the count reads 0xFF and later requests cause no memory access.
- R6: Normal-mode completion sets status bit 0 whatever the mask holds. irq equals status AND NOT mask, so a masked completion leaves irq low until the mask is cleared.
- R7: Writing 1 to bit 0 of register 5 clears the status flag and thereby irq.
- R8: In ring mode the count wraps from 0 to 0xFF and transfers continue. Neither the wrap nor a software clear of enable sets the status flag or irq.
- R9: Requests that arrive while enable is 0 cause no memory access, neither then nor after a later enable.
- R10: Any number of rising request edges during one transfer collapse into a single pending request, which runs one more transfer.
- R11: A halfword transfer copies all 16 bits, little-endian. A byte transfer copies bits [7:0] and drives mem_wdata[15:8] as 0.
- R12: A request held high starts only one transfer, because only rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_sel | input | 3 | Readback select |
| rd_data | output | 16 | Readback data, registered |
| xfer_req | input | 1 | Transfer request, rising-edge sensitive |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | 1 = halfword access, 0 = byte |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong transfer count shows up on the ports within one transfer of the expected end, in two ways. Either a write appears after the enable should have dropped, or an expected write never comes, and the count readback differs from 0xFF. A stuck or mis-stepped address register shows up on mem_addr in the very next transfer of the affected side. A corrupted pending flag shows as a missing or extra write strobe within four cycles of the transfer that should have absorbed it. A status flag raised in ring mode reaches irq in the same cycle it is set.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {S_IDLE, S_READ, S_CAPT, S_WRITE} dmach_state_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_MASK = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  localparam int CB_EN    = 0;
  localparam int CB_RING  = 1;
  localparam int CB_HALF  = 2;
  localparam int CB_SINC  = 3;
  localparam int CB_DINC  = 4;
  localparam int CTRL_W   = 5;

  localparam int DATA_W   = 16;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        waddr,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              step,
  input  logic              last,
  output logic [CTRL_W-1:0] ctrl,
  output logic              mask,
  output logic              status
);
  logic final_xfer;
  logic ring;
  logic en;

  assign ring = ctrl[CB_RING];
  assign en   = ctrl[CB_EN];
  assign final_xfer = step && last && !ring;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      mask   <= 1'b0;
      status <= 1'b0;
    end else begin
      if (we && waddr == REG_CTRL) begin
        ctrl <= wbits;
      end
      if (final_xfer) begin
        ctrl[CB_EN] <= 1'b0;
      end
      if (we && waddr == REG_MASK) begin
        mask <= wbits[0];
      end
      if (final_xfer) begin
        status <= 1'b1;
      end else if (we && waddr == REG_STAT && wbits[0]) begin
        status <= 1'b0;
      end
    end
  end

  AST_RING_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (ring && !status) |=> !status);  // R8

  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> !en);  // R5
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc,
  input  logic          half,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_H = AW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (step) begin
      if (inc) begin
        addr <= addr + (half ? STEP_H : STEP_B);
      end
    end else if (load) begin
      addr <= load_val;
    end
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(addr));  // R3
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              half,
  input  logic              xfer_req,
  input  logic              cnt_load,
  input  logic [CW-1:0]     cnt_val,
  input  logic [AW-1:0]     src_addr,
  input  logic [AW-1:0]     dst_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              step,
  output logic              last,
  output logic [CW-1:0]     count
);
  localparam int HB = DATA_W / 2;

  dmach_state_e state, state_n;
  logic req_q;
  logic pending;
  logic rise;
  logic start;
  logic [DATA_W-1:0] captured;

  assign rise  = xfer_req && !req_q;
  assign start = (state == S_IDLE) && en && (rise || pending);
  assign step  = (state == S_WRITE);
  assign last  = (count == '0);
  assign captured = half ? mem_rdata : {{HB{1'b0}}, mem_rdata[HB-1:0]};

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE:  if (start) state_n = S_READ;
      S_READ:  state_n = S_CAPT;
      S_CAPT:  state_n = S_WRITE;
      S_WRITE: state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      req_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      state <= state_n;
      req_q <= xfer_req;
      if (!en) begin
        pending <= 1'b0;
      end else if (start) begin
        pending <= 1'b0;
      end else if (rise) begin
        pending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '1;
    end else if (step) begin
      count <= count - 1'b1;
    end else if (cnt_load) begin
      count <= cnt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_half  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= (state_n == S_READ) || (state_n == S_WRITE);
      if (state_n == S_READ) begin
        mem_we   <= 1'b0;
        mem_half <= half;
        mem_addr <= src_addr;
      end else if (state_n == S_WRITE) begin
        mem_we    <= 1'b1;
        mem_half  <= half;
        mem_addr  <= dst_addr;
        mem_wdata <= captured;
      end else begin
        mem_we <= 1'b0;
      end
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && state == S_IDLE) |=> (state == S_IDLE));  // R9

  AST_ONE_READ_PER_START: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> $past(state == S_IDLE));  // R10
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [2:0]        rd_sel,
  output logic [15:0]       rd_data,
  input  logic              xfer_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              irq
);
  localparam int NADDR = 2;

  logic [CTRL_W-1:0] ctrl;
  logic              mask;
  logic              status;
  logic              step;
  logic              last;
  logic [CW-1:0]     count;
  logic [AW-1:0]     addr_q [NADDR];
  logic              addr_inc [NADDR];
  logic              addr_load [NADDR];

  assign addr_inc[0]  = ctrl[CB_SINC];
  assign addr_inc[1]  = ctrl[CB_DINC];
  assign addr_load[0] = cfg_we && (cfg_addr == REG_SRC);
  assign addr_load[1] = cfg_we && (cfg_addr == REG_DST);

  dmach_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .waddr  (cfg_addr),
    .wbits  (cfg_wdata[CTRL_W-1:0]),
    .step   (step),
    .last   (last),
    .ctrl   (ctrl),
    .mask   (mask),
    .status (status)
  );

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dmach_addr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst      (rst),
      .load     (addr_load[g]),
      .load_val (AW'(cfg_wdata)),
      .step     (step),
      .inc      (addr_inc[g]),
      .half     (ctrl[CB_HALF]),
      .addr     (addr_q[g])
    );
  end

  dmach_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl[CB_EN]),
    .half      (ctrl[CB_HALF]),
    .xfer_req  (xfer_req),
    .cnt_load  (cfg_we && (cfg_addr == REG_CNT)),
    .cnt_val   (cfg_wdata[CW-1:0]),
    .src_addr  (addr_q[0]),
    .dst_addr  (addr_q[1]),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_half  (mem_half),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .step      (step),
    .last      (last),
    .count     (count)
  );

  assign irq = status && !mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        REG_CTRL: rd_data <= 16'(ctrl);
        REG_SRC:  rd_data <= 16'(addr_q[0]);
        REG_DST:  rd_data <= 16'(addr_q[1]);
        REG_CNT:  rd_data <= 16'(count);
        REG_MASK: rd_data <= 16'(mask);
        REG_STAT: rd_data <= 16'(status);
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));  // R2

  AST_MASK_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($rose(status) && mask) |-> !irq);  // R6
endmodule

// File: tb/dmach_top_bench.sv
module dmach_top_bench;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        xfer_req = 1'b0;
  logic        mem_req, mem_we, mem_half;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq;

  logic [7:0] mem [256];
  int wr_count = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmach_top #(.AW(AW), .CW(8)) u_dmach_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .xfer_req(xfer_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_half(mem_half), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= {mem[8'(mem_addr + 1)], mem[mem_addr[7:0]]};
    end
    if (mem_req && mem_we) begin
      wr_count <= wr_count + 1;
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_half) mem[8'(mem_addr + 1)] <= mem_wdata[15:8];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_sel = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse();
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    rd(3'd0, v); check(v == 16'h0, "R1 ctrl", v, 0);
    rd(3'd1, v); check(v == 16'h0, "R1 src", v, 0);
    rd(3'd2, v); check(v == 16'h0, "R1 dst", v, 0);
    rd(3'd3, v); check(v == 16'hFF, "R1 count", v, 16'hFF);
    rd(3'd4, v); check(v == 16'h0, "R1 mask", v, 0);
    rd(3'd5, v); check(v == 16'h0, "R1 status", v, 0);
  endtask

  task automatic t_disabled();
    int w0;
    bit seen;
    w0 = wr_count;
    seen = 1'b0;
    wr(3'd1, 16'h0010); wr(3'd2, 16'h0080); wr(3'd3, 16'h0003);
    pulse();
    repeat (5) begin
      @(negedge clk);
      if (mem_req) seen = 1'b1;
    end
    check(!seen, "R9 access while disabled", seen, 0);
    wr(3'd0, 16'h0019);
    settle();
    check(wr_count == w0, "R9 no late transfer", wr_count, w0);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_timing_normal();
    logic [15:0] v;
    logic [15:0] exp;
    int w0;
    wr(3'd1, 16'h0020); wr(3'd2, 16'h0090); wr(3'd3, 16'h0002);
    wr(3'd0, 16'h0019);
    exp = {8'h00, mem[8'h20]};
    pulse();
    check(mem_req && !mem_we && mem_addr == 16'h0020, "R2 read cycle", {mem_req, mem_we, mem_addr}, {2'b10, 16'h0020});
    @(negedge clk);
    check(!mem_req, "R2 gap cycle", mem_req, 0);
    @(negedge clk);
    check(mem_req && mem_we && mem_addr == 16'h0090, "R2 write cycle", {mem_req, mem_we, mem_addr}, {2'b11, 16'h0090});
    check(mem_wdata == exp, "R11 byte data upper zero", mem_wdata, exp);
    settle();
    rd(3'd1, v); check(v == 16'h0021, "R4 src byte step", v, 16'h0021);
    pulse(); settle();
    rd(3'd0, v); check(v[0] == 1'b1, "R5 enabled before last", v, 1);
    pulse(); settle();
    rd(3'd0, v); check(v[0] == 1'b0, "R5 enable cleared", v, 0);
    rd(3'd3, v); check(v == 16'hFF, "R5 count FF", v, 16'hFF);
    rd(3'd2, v); check(v == 16'h0093, "R4 dst after three", v, 16'h0093);
    rd(3'd5, v); check(v == 16'h1, "R6 status set", v, 1);
    check(irq == 1'b1, "R6 irq unmasked", irq, 1);
    w0 = wr_count;
    pulse(); settle();
    check(wr_count == w0, "R5 request after end ignored", wr_count, w0);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); check(v == 16'h0, "R7 status cleared", v, 0);
    check(irq == 1'b0, "R7 irq cleared", irq, 0);
  endtask

  task automatic t_mask_half_fixed();
    logic [15:0] v;
    logic [15:0] exp;
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0040); wr(3'd2, 16'h00A0); wr(3'd3, 16'h0001);
    wr(3'd0, 16'h0015);
    exp = {mem[8'h41], mem[8'h40]};
    pulse(); settle();
    pulse(); settle();
    check({mem[8'hA3], mem[8'hA2]} == exp, "R11 halfword copy", {mem[8'hA3], mem[8'hA2]}, exp);
    rd(3'd1, v); check(v == 16'h0040, "R3 fixed src", v, 16'h0040);
    rd(3'd2, v); check(v == 16'h00A4, "R4 dst halfword step", v, 16'h00A4);
    rd(3'd5, v); check(v == 16'h1, "R6 status under mask", v, 1);
    check(irq == 1'b0, "R6 irq masked", irq, 0);
    wr(3'd4, 16'h0000);
    check(irq == 1'b1, "R6 irq after unmask", irq, 1);
    wr(3'd5, 16'h0001);
  endtask

  task automatic t_ring();
    logic [15:0] v;
    int w0;
    w0 = wr_count;
    wr(3'd1, 16'h0050); wr(3'd2, 16'h00C0); wr(3'd3, 16'h0001);
    wr(3'd0, 16'h0003);
    repeat (4) begin pulse(); settle(); end
    check(wr_count == w0 + 4, "R8 ring continues", wr_count, w0 + 4);
    rd(3'd3, v); check(v == 16'hFD, "R8 count wrapped", v, 16'hFD);
    rd(3'd5, v); check(v == 16'h0, "R8 no status on wrap", v, 0);
    wr(3'd0, 16'h0002);
    settle();
    rd(3'd5, v); check(v == 16'h0, "R8 no status on stop", v, 0);
    check(irq == 1'b0, "R8 irq low", irq, 0);
    w0 = wr_count;
    pulse(); settle();
    check(wr_count == w0, "R8 stopped", wr_count, w0);
  endtask

  task automatic t_pending_level();
    int w0;
    wr(3'd1, 16'h0060); wr(3'd2, 16'h00D0); wr(3'd3, 16'h0009);
    wr(3'd0, 16'h0019);
    w0 = wr_count;
    pulse(); pulse(); pulse();
    repeat (10) @(negedge clk);
    check(wr_count == w0 + 2, "R10 pending collapses", wr_count, w0 + 2);
    w0 = wr_count;
    @(negedge clk); xfer_req = 1'b1;
    repeat (12) @(negedge clk);
    xfer_req = 1'b0;
    settle();
    check(wr_count == w0 + 1, "R12 level one transfer", wr_count, w0 + 1);
    wr(3'd0, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_timing_normal();
    t_mask_half_fixed();
    t_ring();
    t_pending_level();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule